// File: doc/BRIEF.md
# Modulator Output Stage with Port Pin Override

This block is the output end of a timer modulator. It holds a toggle flip-flop that inverts on each modulator clock enable pulse while the timer runs. Software can set the flip-flop to a chosen value through a preset write, but the write only has an effect while the timer is stopped. The value is loaded at the clock edge of the write itself, without waiting for a modulator pulse.

The stage also sits in front of a general-purpose port. In modes that need them, two port pins carry the toggle output and its complement in place of the port data register. The data-direction bits still decide whether each pin drives. In the serial modes, a third pin is held as an input whatever its direction bit says. Pin input levels pass through a two-flop synchronizer before they appear on the read-back port. The counter that makes the modulator clock enable is outside this block.

Top module: `mod_out_stage`

## Requirements
- R1: After reset `tog_o` is 0 and `pin_rd_o` is all zeros.
- R2: With `tmr_en_i`=1, a cycle with `mod_tick_i`=1 inverts `tog_o` at that clock edge. A cycle with `mod_tick_i`=0 keeps `tog_o` unchanged.
- R3: With `tmr_en_i`=0, a cycle with `preset_we_i`=1 loads `preset_val_i` into `tog_o` at that same clock edge.
- R4: With `tmr_en_i`=1, `preset_we_i` has no effect on `tog_o`.
- R5: With `tmr_en_i`=0, `mod_tick_i` never toggles `tog_o`. If a preset write and a tick come in the same cycle, `tog_o` takes the preset value.
- R6: In mode 2'b01 (toggle pins) and mode 2'b10 (serial), pin 5 drives `tog_o` and pin 6 drives its complement, whatever the port data register holds.
- R7: For every pin, `pin_oe_o[i]` is 1 only if `port_dir_i[i]` is 1. This also holds for pins 5 and 6 while they are overridden.
- R8: In mode 2'b10 (serial) and mode 2'b11 (serial, no pin override), `pin_oe_o[7]` is 0 whatever `port_dir_i[7]` is.
- R9: In mode 2'b00 (port) and mode 2'b11, every `pin_o[i]` equals `port_data_i[i]`. Outside R6 and R8, `pin_oe_o` equals `port_dir_i`.
- R10: `pin_rd_o` shows `pin_i` two clock edges later. It does not show it after only one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tmr_en_i | input | 1 | Timer running |
| mod_tick_i | input | 1 | Single-cycle modulator clock enable |
| preset_we_i | input | 1 | Preset write strobe |
| preset_val_i | input | 1 | Preset value for the toggle output |
| mode_i | input | 2 | Modulator mode: 00 port, 01 toggle pins, 10 serial, 11 serial without pin override |
| port_data_i | input | 8 | Port data register |
| port_dir_i | input | 8 | Port direction register, 1 means output |
| pin_i | input | 8 | Pin input levels |
| pin_o | output | 8 | Pin drive values |
| pin_oe_o | output | 8 | Pin output enables |
| pin_rd_o | output | 8 | Synchronized pin read-back |
| tog_o | output | 1 | Toggle flip-flop output |

## Verification
Each of the four modes is tried with data patterns chosen so that the port data bits on pins 5 and 6 differ from the toggle value and its complement. This shows whether the override or the data register drives those pins. The direction patterns leave pins 5 to 7 set to output in some vectors and to input in others. This separates direction gating (R7) from the serial-mode forcing of pin 7 (R8). Directed sequences send ticks and preset writes with the timer on and off, and a preset write and a tick in the same cycle. These show whether the preset gating and the tick gating work independently of each other.

// File: rtl/mod_out_pkg.sv
package mod_out_pkg;
  typedef enum logic [1:0] {
    MODE_PORT   = 2'b00,
    MODE_TOG    = 2'b01,
    MODE_SER    = 2'b10,
    MODE_SER_IN = 2'b11
  } mod_mode_e;

  function automatic logic mode_uses_pins(input logic [1:0] m);
    return (m == MODE_TOG) || (m == MODE_SER);
  endfunction

  function automatic logic mode_forces_in(input logic [1:0] m);
    return (m == MODE_SER) || (m == MODE_SER_IN);
  endfunction
endpackage

// File: rtl/mod_toggle_ff.sv
module mod_toggle_ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tmr_en_i,
  input  logic mod_tick_i,
  input  logic preset_we_i,
  input  logic preset_val_i,
  output logic tog_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         tog_q <= 1'b0;
    else if (!tmr_en_i && preset_we_i)   tog_q <= preset_val_i;
    else if (tmr_en_i && mod_tick_i)     tog_q <= ~tog_q;
  end

  assign tog_o = tog_q;
endmodule

// File: rtl/mod_pin_mux.sv
module mod_pin_mux #(
  parameter int PORT_W  = 8,
  parameter int PIN_A   = 5,
  parameter int PIN_B   = 6,
  parameter int PIN_SER = 7
) (
  input  logic              tog_i,
  input  logic [1:0]        mode_i,
  input  logic [PORT_W-1:0] port_data_i,
  input  logic [PORT_W-1:0] port_dir_i,
  output logic [PORT_W-1:0] pin_o,
  output logic [PORT_W-1:0] pin_oe_o
);
  import mod_out_pkg::*;

  logic use_pins, force_in;
  assign use_pins = mode_uses_pins(mode_i);
  assign force_in = mode_forces_in(mode_i);

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    if (i == PIN_A) begin : g_a
      assign pin_o[i]    = use_pins ? tog_i : port_data_i[i];
      assign pin_oe_o[i] = port_dir_i[i];
    end else if (i == PIN_B) begin : g_b
      assign pin_o[i]    = use_pins ? ~tog_i : port_data_i[i];
      assign pin_oe_o[i] = port_dir_i[i];
    end else if (i == PIN_SER) begin : g_ser
      assign pin_o[i]    = port_data_i[i];
      assign pin_oe_o[i] = port_dir_i[i] & ~force_in;
    end else begin : g_gp
      assign pin_o[i]    = port_data_i[i];
      assign pin_oe_o[i] = port_dir_i[i];
    end
  end
endmodule

// File: rtl/mod_pin_sync.sv
module mod_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/mod_out_stage.sv
module mod_out_stage #(
  parameter int PORT_W      = 8,
  parameter int PIN_A       = 5,
  parameter int PIN_B       = 6,
  parameter int PIN_SER     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tmr_en_i,
  input  logic              mod_tick_i,
  input  logic              preset_we_i,
  input  logic              preset_val_i,
  input  logic [1:0]        mode_i,
  input  logic [PORT_W-1:0] port_data_i,
  input  logic [PORT_W-1:0] port_dir_i,
  input  logic [PORT_W-1:0] pin_i,
  output logic [PORT_W-1:0] pin_o,
  output logic [PORT_W-1:0] pin_oe_o,
  output logic [PORT_W-1:0] pin_rd_o,
  output logic              tog_o
);
  logic tog;

  mod_toggle_ff i_tog (
    .clk_i, .rst_ni, .tmr_en_i, .mod_tick_i, .preset_we_i, .preset_val_i,
    .tog_o(tog)
  );

  mod_pin_mux #(.PORT_W(PORT_W), .PIN_A(PIN_A), .PIN_B(PIN_B), .PIN_SER(PIN_SER)) i_mux (
    .tog_i(tog), .mode_i, .port_data_i, .port_dir_i, .pin_o, .pin_oe_o
  );

  mod_pin_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_rd_o)
  );

  assign tog_o = tog;
endmodule

// File: rtl/mod_out_chk.sv
module mod_out_chk #(
  parameter int PORT_W  = 8,
  parameter int PIN_A   = 5,
  parameter int PIN_B   = 6,
  parameter int PIN_SER = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tmr_en_i,
  input logic              mod_tick_i,
  input logic              preset_we_i,
  input logic              preset_val_i,
  input logic [1:0]        mode_i,
  input logic [PORT_W-1:0] port_dir_i,
  input logic [PORT_W-1:0] pin_o,
  input logic [PORT_W-1:0] pin_oe_o,
  input logic              tog_o
);
  AST_TOGGLE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_en_i && mod_tick_i) |=> (tog_o != $past(tog_o)));  // R2
  AST_PRESET_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmr_en_i && preset_we_i) |=> (tog_o == $past(preset_val_i)));  // R3
  AST_RUN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_en_i && !mod_tick_i) |=> $stable(tog_o));  // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmr_en_i && !preset_we_i) |=> $stable(tog_o));  // R5
  AST_PIN_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 || mode_i == 2'b10) |->
      (pin_o[PIN_A] == tog_o && pin_o[PIN_B] == !tog_o));  // R6
  AST_DIR_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_oe_o & ~port_dir_i) == '0));  // R7
  AST_SER_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[1] |-> !pin_oe_o[PIN_SER]);  // R8
endmodule

bind mod_out_stage mod_out_chk #(
  .PORT_W(PORT_W), .PIN_A(PIN_A), .PIN_B(PIN_B), .PIN_SER(PIN_SER)
) i_mod_out_chk (
  .clk_i, .rst_ni, .tmr_en_i, .mod_tick_i, .preset_we_i, .preset_val_i,
  .mode_i, .port_dir_i, .pin_o, .pin_oe_o, .tog_o
);

// File: tb/test_mod_out_stage.sv
`timescale 1ns/1ps
module test_mod_out_stage;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tmr_en = 1'b0, tick = 1'b0, pwe = 1'b0, pval = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] pdata = '0, pdir = '0, pin_in = '0;
  logic [7:0] pin_out, pin_oe, pin_rd;
  logic       tog;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mod_out_stage i_mod_out_stage (
    .clk_i(clk), .rst_ni(rst_n), .tmr_en_i(tmr_en), .mod_tick_i(tick),
    .preset_we_i(pwe), .preset_val_i(pval), .mode_i(mode),
    .port_data_i(pdata), .port_dir_i(pdir), .pin_i(pin_in),
    .pin_o(pin_out), .pin_oe_o(pin_oe), .pin_rd_o(pin_rd), .tog_o(tog)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one edge: drive at negedge, sample 1 ns after posedge
  task automatic step();
    @(posedge clk); #1;
    tick = 1'b0; pwe = 1'b0;
  endtask

  task automatic do_preset(input logic v);
    @(negedge clk); tmr_en = 1'b0; pwe = 1'b1; pval = v;
    step();
  endtask

  // mode, toggle preset, data, dir, expected pin_o, expected pin_oe
  typedef struct packed {
    logic [1:0] mode; logic tg; logic [7:0] data, dir, exp_o, exp_oe;
  } vec_t;
  localparam vec_t VECS [8] = '{
    '{2'b00, 1'b0, 8'hA5, 8'hFF, 8'hA5, 8'hFF},  // R9 port mode
    '{2'b01, 1'b1, 8'h00, 8'hFF, 8'h20, 8'hFF},  // R6 tog=1
    '{2'b01, 1'b0, 8'hFF, 8'hFF, 8'hDF, 8'hFF},  // R6 tog=0
    '{2'b01, 1'b1, 8'h00, 8'h00, 8'h20, 8'h00},  // R7 no dir
    '{2'b10, 1'b0, 8'h80, 8'hFF, 8'hC0, 8'h7F},  // R8 serial
    '{2'b11, 1'b1, 8'h0F, 8'hE0, 8'h0F, 8'h60},  // R8/R9 serial, no override
    '{2'b10, 1'b1, 8'h00, 8'h9F, 8'h20, 8'h1F},  // R7/R8
    '{2'b00, 1'b1, 8'h5A, 8'h80, 8'h5A, 8'h80}   // R9
  };

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    check("R1 tog after reset", {7'd0, tog}, 8'h00);
    check("R1 rd after reset", pin_rd, 8'h00);

    for (int k = 0; k < 8; k++) begin
      do_preset(VECS[k].tg);
      @(negedge clk);
      mode = VECS[k].mode; pdata = VECS[k].data; pdir = VECS[k].dir;
      #1;
      check($sformatf("R6/R9 pin_o vec%0d", k), pin_out, VECS[k].exp_o);
      check($sformatf("R7/R8 pin_oe vec%0d", k), pin_oe, VECS[k].exp_oe);
      check($sformatf("R3 tog vec%0d", k), {7'd0, tog}, {7'd0, VECS[k].tg});
    end
    mode = 2'b00; pdir = '0; pdata = '0;

    // R3: preset loads at the write edge
    do_preset(1'b1);
    check("R3 preset 1", {7'd0, tog}, 8'h01);
    do_preset(1'b0);
    check("R3 preset 0", {7'd0, tog}, 8'h00);

    // R2: ticks while running
    @(negedge clk); tmr_en = 1'b1; tick = 1'b1; step();
    check("R2 tick 1", {7'd0, tog}, 8'h01);
    @(negedge clk); step();
    check("R2 no tick holds", {7'd0, tog}, 8'h01);
    @(negedge clk); tick = 1'b1; step();
    check("R2 tick 2", {7'd0, tog}, 8'h00);

    // R4: preset while running ignored
    @(negedge clk); pwe = 1'b1; pval = 1'b1; step();
    check("R4 preset while running", {7'd0, tog}, 8'h00);

    // R5: tick while disabled ignored; preset+tick same cycle
    @(negedge clk); tmr_en = 1'b0; tick = 1'b1; step();
    check("R5 tick disabled", {7'd0, tog}, 8'h00);
    @(negedge clk); tick = 1'b1; pwe = 1'b1; pval = 1'b1; step();
    check("R5 preset with tick", {7'd0, tog}, 8'h01);
    @(negedge clk); tick = 1'b1; pwe = 1'b1; pval = 1'b1; step();
    check("R5 preset with tick repeat", {7'd0, tog}, 8'h01);

    // R10: two-edge synchronizer
    @(negedge clk); pin_in = 8'h3C;
    @(posedge clk); #1;
    check("R10 one edge", pin_rd, 8'h00);
    @(posedge clk); #1;
    check("R10 two edges", pin_rd, 8'h3C);
    @(negedge clk); pin_in = 8'hC3;
    @(posedge clk); @(posedge clk); #1;
    check("R10 second pattern", pin_rd, 8'hC3);

    // R1: reset mid-run clears state
    @(negedge clk); rst_n = 1'b0; #1;
    check("R1 tog in reset", {7'd0, tog}, 8'h00);
    check("R1 rd in reset", pin_rd, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule